// File: doc/BRIEF.md
# Interlace-Capable Panel Vertical Timing Generator

This block derives the vertical timing of a TFT or TV style display from a stream of line-start strobes. Each strobe marks the beginning of one display line; the block places that line in one of four consecutive regions of a field: the sync pulse lines, the leading blank lines, the active lines and the trailing blank lines. From this it drives an active-high VSYNC, a vertical active enable, a field identifier and two single-clock pulses (field start and active-region start) for a downstream fetch engine.

Two sets of timing counts are presented on its inputs, one for odd fields and one for even fields. In progressive operation only the odd set is used and every field is an odd field. In interlaced operation the block alternates odd and even fields and applies the matching set. The set for a field is captured at the field boundary, so a set may be rewritten at any time during a field. For STN-style panels, bit 0 of the trailing wait count can hold back the rise of VSYNC until the next falling edge of HSYNC.

Top module: `lcd_vtiming_gen`

## Requirements
- R1: After reset, vsync, vactive, field_id, frame_start and act_start are all 0, and they stay so until the first line_stb, which begins the first line of an odd field (field_id = 0).
- R2: Each field consists of pulse-width lines, then leading-wait lines, then active lines, then trailing-wait lines, each count taken from the set captured for that field; a line lasts from one line_stb to the next.
- R3: vsync is 1 exactly during the pulse lines of a field (subject to R11); a pulse width of 0 leaves vsync at 0 for the whole field.
- R4: vactive is 1 exactly during the active lines of a field and 0 on all blank and pulse lines.
- R5: frame_start is 1 for the single clock following the line_stb that begins a field; act_start is 1 for the single clock following the line_stb that begins the first active line of a field.
- R6: With prog_mode = 0 the field_id toggles at every field boundary (0 = odd, 1 = even) and an even field uses the even set.
- R7: With prog_mode = 1 the field_id stays 0, every field uses the odd set, and the even set has no effect.
- R8: The set is captured at the line_stb that begins a field; changes to the inputs during a field do not alter that field and apply from the next one.
- R9: A count of 0 in any region removes that region; when both the pulse width and the leading wait are 0, frame_start and act_start fall in the same clock.
- R10: A field whose four counts are all 0 lasts exactly one blank line, so each line_stb begins a new field.
- R11: With stn_mode = 1 and bit 0 of the captured trailing wait count set, vsync stays 0 at the start of the pulse lines and rises one clock after the first falling edge of hsync seen during them; otherwise it rises with the pulse lines.
- R12: Between line strobes vactive and field_id do not change, and vsync changes only as R11 allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-clock strobe at the start of each line |
| hsync | input | 1 | Horizontal sync level, used for STN alignment |
| prog_mode | input | 1 | 1 = progressive, 0 = interlaced |
| stn_mode | input | 1 | 1 = STN panel, enables VSYNC alignment option |
| odd_pulse_w | input | 6 | Odd set: VSYNC pulse width in lines |
| odd_act_lines | input | 11 | Odd set: active lines |
| odd_lead_wait | input | 8 | Odd set: blank lines before the active lines |
| odd_trail_wait | input | 9 | Odd set: blank lines after the active lines; bit 0 is the STN delay request |
| even_pulse_w | input | 6 | Even set: VSYNC pulse width in lines |
| even_act_lines | input | 11 | Even set: active lines |
| even_lead_wait | input | 8 | Even set: blank lines before the active lines |
| even_trail_wait | input | 9 | Even set: blank lines after the active lines; bit 0 is the STN delay request |
| vsync | output | 1 | Vertical sync, active high |
| vactive | output | 1 | Vertical active region enable |
| field_id | output | 1 | Current field, 0 = odd, 1 = even |
| frame_start | output | 1 | One-clock pulse when a field begins |
| act_start | output | 1 | One-clock pulse when the active region begins |

## Verification
The field-start pulse and the active-start pulse coincide when a field has no pulse lines and no leading wait, because the strobe that opens the field also opens its first active line. The bench provokes this by programming only active lines (and, separately, a field with a single active line) and judges that both pulses and vactive appear in the one clock after that strobe with vsync held low. A second collision, a field boundary arriving while the inputs were rewritten mid-field, is judged by checking that the old counts finish the current field and the new counts shape the next.

// File: rtl/lcd_vt_pkg.sv
package lcd_vt_pkg;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_LEAD  = 2'd1,
      PH_ACT   = 2'd2,
      PH_TRAIL = 2'd3
   } vt_phase_e;

   localparam int unsigned VT_NUM_PH = 4;

   // Lowest-numbered set bit of a region mask; an empty mask yields the
   // trailing region, which the sequencer uses for a degenerate field.
   function automatic logic [1:0] vt_first_set(input logic [VT_NUM_PH-1:0] m);
      logic [1:0] r;
      r = 2'd3;
      for (int i = VT_NUM_PH - 1; i >= 0; i--) begin
         if (m[i]) r = 2'(i);
      end
      return r;
   endfunction

endpackage

// File: rtl/lcd_vt_cfg_sel.sv
module lcd_vt_cfg_sel #(
   parameter int unsigned PW_W    = 6,
   parameter int unsigned ACT_W   = 11,
   parameter int unsigned LEAD_W  = 8,
   parameter int unsigned TRAIL_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               boundary,
   input  logic               running,
   input  logic               prog_mode,
   input  logic [PW_W-1:0]    odd_pw,
   input  logic [ACT_W-1:0]   odd_act,
   input  logic [LEAD_W-1:0]  odd_lead,
   input  logic [TRAIL_W-1:0] odd_trail,
   input  logic [PW_W-1:0]    even_pw,
   input  logic [ACT_W-1:0]   even_act,
   input  logic [LEAD_W-1:0]  even_lead,
   input  logic [TRAIL_W-1:0] even_trail,
   output logic               field_id,
   output logic [PW_W-1:0]    nxt_pw,
   output logic [ACT_W-1:0]   nxt_act,
   output logic [LEAD_W-1:0]  nxt_lead,
   output logic [TRAIL_W-1:0] nxt_trail,
   output logic [PW_W-1:0]    cur_pw,
   output logic [ACT_W-1:0]   cur_act,
   output logic [LEAD_W-1:0]  cur_lead,
   output logic [TRAIL_W-1:0] cur_trail
);

   logic nxt_field;

   // The first field after reset is always odd; afterwards the flag
   // alternates only in interlaced operation.
   assign nxt_field = (running && !prog_mode) ? ~field_id : 1'b0;

   always_comb begin
      if (nxt_field) begin
         nxt_pw    = even_pw;
         nxt_act   = even_act;
         nxt_lead  = even_lead;
         nxt_trail = even_trail;
      end else begin
         nxt_pw    = odd_pw;
         nxt_act   = odd_act;
         nxt_lead  = odd_lead;
         nxt_trail = odd_trail;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_id  <= 1'b0;
         cur_pw    <= '0;
         cur_act   <= '0;
         cur_lead  <= '0;
         cur_trail <= '0;
      end else if (boundary) begin
         field_id  <= nxt_field;
         cur_pw    <= nxt_pw;
         cur_act   <= nxt_act;
         cur_lead  <= nxt_lead;
         cur_trail <= nxt_trail;
      end
   end

endmodule

// File: rtl/lcd_vt_seq.sv
module lcd_vt_seq
   import lcd_vt_pkg::*;
#(
   parameter int unsigned PW_W    = 6,
   parameter int unsigned ACT_W   = 11,
   parameter int unsigned LEAD_W  = 8,
   parameter int unsigned TRAIL_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_stb,
   input  logic [PW_W-1:0]    cur_pw,
   input  logic [ACT_W-1:0]   cur_act,
   input  logic [LEAD_W-1:0]  cur_lead,
   input  logic [TRAIL_W-1:0] cur_trail,
   input  logic [PW_W-1:0]    nxt_pw,
   input  logic [ACT_W-1:0]   nxt_act,
   input  logic [LEAD_W-1:0]  nxt_lead,
   input  logic [TRAIL_W-1:0] nxt_trail,
   output logic               running,
   output vt_phase_e          phase,
   output logic               boundary,
   output logic               sync_enter,
   output logic               frame_start,
   output logic               act_start
);

   localparam int unsigned MAX_A = (PW_W > ACT_W) ? PW_W : ACT_W;
   localparam int unsigned MAX_B = (LEAD_W > TRAIL_W) ? LEAD_W : TRAIL_W;
   localparam int unsigned CNT_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;

   logic [CNT_W-1:0]     cur_len [VT_NUM_PH];
   logic [CNT_W-1:0]     nxt_len [VT_NUM_PH];
   logic [VT_NUM_PH-1:0] cur_mask;
   logic [VT_NUM_PH-1:0] nxt_mask;
   logic [VT_NUM_PH-1:0] above;
   logic [VT_NUM_PH-1:0] later;
   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     len_now;
   logic                 at_end;
   logic                 last_line;
   logic                 step;
   vt_phase_e            first_ph;
   vt_phase_e            step_ph;

   assign cur_len[0] = CNT_W'(cur_pw);
   assign cur_len[1] = CNT_W'(cur_lead);
   assign cur_len[2] = CNT_W'(cur_act);
   assign cur_len[3] = CNT_W'(cur_trail);
   assign nxt_len[0] = CNT_W'(nxt_pw);
   assign nxt_len[1] = CNT_W'(nxt_lead);
   assign nxt_len[2] = CNT_W'(nxt_act);
   assign nxt_len[3] = CNT_W'(nxt_trail);

   for (genvar g = 0; g < VT_NUM_PH; g++) begin : g_mask
      assign cur_mask[g] = |cur_len[g];
      assign nxt_mask[g] = |nxt_len[g];
   end

   assign len_now = cur_len[phase];
   assign at_end  = (len_now == '0) || (cnt == (len_now - CNT_W'(1)));
   assign above   = 4'b1110 << phase;
   assign later   = cur_mask & above;

   assign last_line  = at_end && (later == '0);
   assign boundary   = line_stb && (!running || last_line);
   assign step       = line_stb && running && at_end && !last_line;
   assign first_ph   = vt_phase_e'(vt_first_set(nxt_mask));
   assign step_ph    = vt_phase_e'(vt_first_set(later));
   assign sync_enter = boundary && (first_ph == PH_SYNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running     <= 1'b0;
         phase       <= PH_SYNC;
         cnt         <= '0;
         frame_start <= 1'b0;
         act_start   <= 1'b0;
      end else if (boundary) begin
         running     <= 1'b1;
         phase       <= first_ph;
         cnt         <= '0;
         frame_start <= 1'b1;
         act_start   <= (first_ph == PH_ACT);
      end else if (step) begin
         phase       <= step_ph;
         cnt         <= '0;
         frame_start <= 1'b0;
         act_start   <= (step_ph == PH_ACT);
      end else begin
         if (line_stb && running) cnt <= cnt + CNT_W'(1);
         frame_start <= 1'b0;
         act_start   <= 1'b0;
      end
   end

endmodule

// File: rtl/lcd_vt_sync_gate.sv
module lcd_vt_sync_gate #(
   parameter bit STN_DELAY_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_enter,
   input  logic delay_req,
   input  logic stn_mode,
   input  logic hsync,
   output logic gate
);

   if (STN_DELAY_EN) begin : g_delay
      logic hsync_q;
      logic gate_q;
      logic hs_fall;

      assign hs_fall = hsync_q && !hsync;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hsync_q <= 1'b0;
            gate_q  <= 1'b0;
         end else begin
            hsync_q <= hsync;
            if (sync_enter)   gate_q <= !(stn_mode && delay_req);
            else if (hs_fall) gate_q <= 1'b1;
         end
      end

      assign gate = gate_q;
   end else begin : g_nodelay
      logic unused_gate_in;
      assign unused_gate_in = ^{clk, rst_n, sync_enter, delay_req, stn_mode, hsync};
      assign gate = 1'b1;
   end

endmodule

// File: rtl/lcd_vtiming_gen.sv
module lcd_vtiming_gen
   import lcd_vt_pkg::*;
#(
   parameter int unsigned PW_W         = 6,
   parameter int unsigned ACT_W        = 11,
   parameter int unsigned LEAD_W       = 8,
   parameter int unsigned TRAIL_W      = 9,
   parameter bit          STN_DELAY_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_stb,
   input  logic               hsync,
   input  logic               prog_mode,
   input  logic               stn_mode,
   input  logic [PW_W-1:0]    odd_pulse_w,
   input  logic [ACT_W-1:0]   odd_act_lines,
   input  logic [LEAD_W-1:0]  odd_lead_wait,
   input  logic [TRAIL_W-1:0] odd_trail_wait,
   input  logic [PW_W-1:0]    even_pulse_w,
   input  logic [ACT_W-1:0]   even_act_lines,
   input  logic [LEAD_W-1:0]  even_lead_wait,
   input  logic [TRAIL_W-1:0] even_trail_wait,
   output logic               vsync,
   output logic               vactive,
   output logic               field_id,
   output logic               frame_start,
   output logic               act_start
);

   if (PW_W < 1 || PW_W > 16) begin : g_bad_pw
      $error("lcd_vtiming_gen: PW_W out of range");
   end
   if (ACT_W < 1 || ACT_W > 16) begin : g_bad_act
      $error("lcd_vtiming_gen: ACT_W out of range");
   end
   if (LEAD_W < 1 || LEAD_W > 16) begin : g_bad_lead
      $error("lcd_vtiming_gen: LEAD_W out of range");
   end
   if (TRAIL_W < 1 || TRAIL_W > 16) begin : g_bad_trail
      $error("lcd_vtiming_gen: TRAIL_W out of range");
   end

   logic               running;
   logic               boundary;
   logic               sync_enter;
   logic               gate;
   vt_phase_e          phase;
   logic [PW_W-1:0]    nxt_pw,    cur_pw;
   logic [ACT_W-1:0]   nxt_act,   cur_act;
   logic [LEAD_W-1:0]  nxt_lead,  cur_lead;
   logic [TRAIL_W-1:0] nxt_trail, cur_trail;

   lcd_vt_cfg_sel #(
      .PW_W(PW_W), .ACT_W(ACT_W), .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W)
   ) i_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary   (boundary),
      .running    (running),
      .prog_mode  (prog_mode),
      .odd_pw     (odd_pulse_w),
      .odd_act    (odd_act_lines),
      .odd_lead   (odd_lead_wait),
      .odd_trail  (odd_trail_wait),
      .even_pw    (even_pulse_w),
      .even_act   (even_act_lines),
      .even_lead  (even_lead_wait),
      .even_trail (even_trail_wait),
      .field_id   (field_id),
      .nxt_pw     (nxt_pw),
      .nxt_act    (nxt_act),
      .nxt_lead   (nxt_lead),
      .nxt_trail  (nxt_trail),
      .cur_pw     (cur_pw),
      .cur_act    (cur_act),
      .cur_lead   (cur_lead),
      .cur_trail  (cur_trail)
   );

   lcd_vt_seq #(
      .PW_W(PW_W), .ACT_W(ACT_W), .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_stb    (line_stb),
      .cur_pw      (cur_pw),
      .cur_act     (cur_act),
      .cur_lead    (cur_lead),
      .cur_trail   (cur_trail),
      .nxt_pw      (nxt_pw),
      .nxt_act     (nxt_act),
      .nxt_lead    (nxt_lead),
      .nxt_trail   (nxt_trail),
      .running     (running),
      .phase       (phase),
      .boundary    (boundary),
      .sync_enter  (sync_enter),
      .frame_start (frame_start),
      .act_start   (act_start)
   );

   lcd_vt_sync_gate #(
      .STN_DELAY_EN(STN_DELAY_EN)
   ) i_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_enter (sync_enter),
      .delay_req  (nxt_trail[0]),
      .stn_mode   (stn_mode),
      .hsync      (hsync),
      .gate       (gate)
   );

   assign vsync   = running && (phase == PH_SYNC) && gate;
   assign vactive = running && (phase == PH_ACT);

endmodule

// File: rtl/lcd_vtiming_chk.sv
module lcd_vtiming_chk (
   input logic clk,
   input logic rst_n,
   input logic line_stb,
   input logic vsync,
   input logic vactive,
   input logic field_id,
   input logic frame_start,
   input logic act_start
);

   // R2: pulse lines and active lines never overlap
   p_sync_act_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(vsync && vactive));

   // R4: the active-start pulse marks an active line
   p_act_start_in_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act_start |-> vactive);

   // R5: both pulses follow a line strobe and last one clock
   p_pulse_after_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start || act_start) |-> $past(line_stb));

   p_fs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   // R6: the field identifier moves only when a field begins
   p_field_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field_id) |-> frame_start);

   // R11: VSYNC ends only at a line boundary
   p_vs_fall_on_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vsync) |-> $past(line_stb));

   // R12: nothing region-related moves without a strobe
   p_quiet_between_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(line_stb) |-> ($stable(vactive) && $stable(field_id)));

endmodule

bind lcd_vtiming_gen lcd_vtiming_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_stb    (line_stb),
   .vsync       (vsync),
   .vactive     (vactive),
   .field_id    (field_id),
   .frame_start (frame_start),
   .act_start   (act_start)
);

// File: tb/test_lcd_vtiming_gen.sv
module test_lcd_vtiming_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_stb = 1'b0;
   logic        hsync = 1'b0;
   logic        prog_mode = 1'b1;
   logic        stn_mode = 1'b0;
   logic [5:0]  odd_pulse_w = '0, even_pulse_w = '0;
   logic [10:0] odd_act_lines = '0, even_act_lines = '0;
   logic [7:0]  odd_lead_wait = '0, even_lead_wait = '0;
   logic [8:0]  odd_trail_wait = '0, even_trail_wait = '0;
   logic        vsync, vactive, field_id, frame_start, act_start;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   lcd_vtiming_gen i_lcd_vtiming_gen (
      .clk             (clk),
      .rst_n           (rst_n),
      .line_stb        (line_stb),
      .hsync           (hsync),
      .prog_mode       (prog_mode),
      .stn_mode        (stn_mode),
      .odd_pulse_w     (odd_pulse_w),
      .odd_act_lines   (odd_act_lines),
      .odd_lead_wait   (odd_lead_wait),
      .odd_trail_wait  (odd_trail_wait),
      .even_pulse_w    (even_pulse_w),
      .even_act_lines  (even_act_lines),
      .even_lead_wait  (even_lead_wait),
      .even_trail_wait (even_trail_wait),
      .vsync           (vsync),
      .vactive         (vactive),
      .field_id        (field_id),
      .frame_start     (frame_start),
      .act_start       (act_start)
   );

   task automatic chk(input logic got, input logic exp, input string what);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", what, got, exp);
      end
   endtask

   task automatic set_odd(input int pw, input int ld, input int ac, input int tr);
      odd_pulse_w = 6'(pw); odd_lead_wait = 8'(ld);
      odd_act_lines = 11'(ac); odd_trail_wait = 9'(tr);
   endtask

   task automatic set_even(input int pw, input int ld, input int ac, input int tr);
      even_pulse_w = 6'(pw); even_lead_wait = 8'(ld);
      even_act_lines = 11'(ac); even_trail_wait = 9'(tr);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; line_stb = 1'b0; hsync = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // One line: strobe, check the clock after it, then check the quiet gap (R12).
   task automatic do_line(input logic vs, input logic ac, input logic fld,
                          input logic fs, input logic as, input string tag);
      @(negedge clk); line_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0;
      chk(vsync, vs, {tag, " vsync"});
      chk(vactive, ac, {tag, " vactive"});
      chk(field_id, fld, {tag, " field_id"});
      chk(frame_start, fs, {tag, " frame_start"});
      chk(act_start, as, {tag, " act_start"});
      repeat (2) @(negedge clk);
      chk(vactive, ac, "R12 vactive held between strobes");
      chk(field_id, fld, "R12 field_id held between strobes");
      chk(vsync, vs, "R12 vsync held between strobes");
      chk(frame_start | act_start, 1'b0, "R5 pulses last one clock");
   endtask

   // Expected lines of a whole field, expanded from the region counts.
   task automatic run_field(input int pw, input int ld, input int ac, input int tr,
                            input logic fld, input string tag);
      int total;
      total = pw + ld + ac + tr;
      if (total == 0) begin
         do_line(1'b0, 1'b0, fld, 1'b1, 1'b0, {tag, " R10 empty field"});
      end else begin
         for (int n = 0; n < total; n++) begin
            do_line(n < pw, (n >= pw + ld) && (n < pw + ld + ac), fld,
                    n == 0, (n == pw + ld) && (ac > 0), tag);
         end
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk(vsync, 1'b0, "R1 vsync after reset");
      chk(vactive, 1'b0, "R1 vactive after reset");
      chk(field_id, 1'b0, "R1 field_id after reset");
      chk(frame_start, 1'b0, "R1 frame_start after reset");
      chk(act_start, 1'b0, "R1 act_start after reset");
      repeat (5) @(negedge clk);
      chk(vsync | vactive | frame_start, 1'b0, "R1 idle without strobe");
   endtask

   task automatic t_progressive();
      prog_mode = 1'b1; stn_mode = 1'b0;
      set_odd(2, 1, 3, 1);
      set_even(1, 4, 1, 2);
      do_reset();
      run_field(2, 1, 3, 1, 1'b0, "R2 R3 R4 R7 prog field 1");
      run_field(2, 1, 3, 1, 1'b0, "R7 prog field 2 ignores even set");
   endtask

   task automatic t_interlaced();
      prog_mode = 1'b0; stn_mode = 1'b0;
      set_odd(2, 1, 3, 1);
      set_even(1, 2, 2, 3);
      do_reset();
      run_field(2, 1, 3, 1, 1'b0, "R6 odd field");
      run_field(1, 2, 2, 3, 1'b1, "R6 even field");
      run_field(2, 1, 3, 1, 1'b0, "R6 odd again");
   endtask

   task automatic t_midfield_write();
      prog_mode = 1'b1; stn_mode = 1'b0;
      set_odd(1, 0, 2, 0);
      do_reset();
      do_line(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 line 0");
      set_odd(0, 0, 1, 0);
      do_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R8 old counts hold");
      do_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 old counts hold");
      run_field(0, 0, 1, 0, 1'b0, "R8 R9 new counts next field");
   endtask

   task automatic t_zero_regions();
      prog_mode = 1'b1; stn_mode = 1'b0;
      set_odd(0, 0, 2, 0);
      do_reset();
      run_field(0, 0, 2, 0, 1'b0, "R9 R3 only active lines");
      set_odd(3, 0, 0, 2);
      run_field(3, 0, 0, 2, 1'b0, "R9 no active lines");
      set_odd(0, 0, 0, 0);
      run_field(0, 0, 0, 0, 1'b0, "R10 first");
      run_field(0, 0, 0, 0, 1'b0, "R10 second");
      set_odd(1, 0, 1, 0);
      run_field(1, 0, 1, 0, 1'b0, "R10 recovery");
   endtask

   task automatic t_stn_align();
      prog_mode = 1'b1; stn_mode = 1'b1;
      set_odd(2, 0, 1, 1);
      do_reset();
      do_line(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 vsync held for hsync edge");
      @(negedge clk); hsync = 1'b1;
      @(negedge clk); hsync = 1'b0;
      @(negedge clk);
      chk(vsync, 1'b1, "R11 vsync after hsync fall");
      do_line(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 second pulse line");
      do_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11 active line");
      set_odd(2, 0, 1, 2);
      do_line(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 trailing line");
      run_field(2, 0, 1, 2, 1'b0, "R11 delay bit clear");
      set_odd(2, 0, 1, 1);
      stn_mode = 1'b0;
      run_field(2, 0, 1, 1, 1'b0, "R11 stn mode off");
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_progressive();
      t_interlaced();
      t_midfield_write();
      t_zero_regions();
      t_stn_align();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule